// File: doc/BRIEF.md
# Transmit Descriptor Fetch Engine

This block drains a transmit descriptor ring in host memory. Software writes a new producer index to the engine's head input. The engine then walks every ring slot between its own consumer count and that index. For each slot it reads the 16-byte descriptor from memory. It then reads the packet buffer that the descriptor points at. When the buffer read completes, it announces the frame to the transmit side and raises a completion request for that slot.

Two read ports reach memory, one for descriptors and one for payload. Each port has a request handshake and a response strobe. A one-entry holding register sits between the two stages. This lets the next descriptor be fetched while the previous payload is still in flight. The payload bytes travel on the memory data path. This engine only marks frame boundaries: length, slot, checksum command and error. The consumer-side tail index is output for software, and it moves only when a payload read finishes.

Top module: `tx_desc_fetch`

## Requirements
- R1: While reset is held and right after it, `tail_ptr` is 0 and `dreq_valid`, `prq_valid`, `tx_valid`, `cpl_valid` are all low.
- R2: A head write acts as a doorbell. Exactly one descriptor read is issued per slot between the internal consumer count and the written head, in increasing order. The request tag equals the 16-bit consumer count, which steps by one per read issued. A doorbell that repeats the current head issues nothing.
- R3: Each descriptor read has length 16. Its address is `ring_base + (tag mod 2^ring_log_size) * 16`, so slots wrap inside the ring.
- R4: The descriptor response is little-endian 128 bits. Bits [15:0] are ignored, [31:16] are the checksum command, [63:32] are the buffer length, and [127:64] are the buffer address. One payload read follows, with that address, the length after R5, and the same tag.
- R5: A descriptor length above 2048 is replaced by 2048 and the frame is marked with `len_err`. A length of exactly 2048 passes unchanged, with `len_err` low.
- R6: One cycle after the payload response strobe, `tx_valid` pulses for one cycle. It carries the frame's length, tag and checksum command.
- R7: `tail_ptr` increments by one with each finished payload read and at no other time. The slot that finishes always equals the tail value before the increment.
- R8: `cpl_valid` pulses in the same cycle as `tx_valid`. It carries `cpl_index` equal to the finished slot and `cpl_len` equal to the frame length.
- R9: While `queue_active` is low, no new descriptor read starts. Slots the doorbell announced are served once it goes high.
- R10: At most one request is outstanding on each read port. A request stays asserted, with stable address, until it is accepted.
- R11: A doorbell written while earlier slots are still in flight extends the work. All slots up to the newest head are served exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | ADDR_W | Byte address of ring slot 0 |
| ring_log_size | input | LOG_W | Log2 of the ring slot count |
| queue_active | input | 1 | Enables new descriptor reads |
| head_wr_valid | input | 1 | Doorbell strobe |
| head_wr_ptr | input | PTR_W | New producer index |
| tail_ptr | output | PTR_W | Count of finished slots |
| dreq_valid | output | 1 | Descriptor read request |
| dreq_ready | input | 1 | Descriptor request accepted |
| dreq_addr | output | ADDR_W | Descriptor address |
| dreq_len | output | LEN_W | Descriptor read length (16) |
| dreq_tag | output | PTR_W | Slot tag of the request |
| drsp_valid | input | 1 | Descriptor data returned |
| drsp_data | input | 128 | Descriptor contents |
| prq_valid | output | 1 | Payload read request |
| prq_ready | input | 1 | Payload request accepted |
| prq_addr | output | ADDR_W | Buffer address |
| prq_len | output | LEN_W | Buffer length |
| prq_tag | output | PTR_W | Slot tag |
| prsp_valid | input | 1 | Payload read finished |
| tx_valid | output | 1 | Frame ready for transmit |
| tx_len | output | LEN_W | Frame length |
| tx_csum_cmd | output | 16 | Checksum command of the frame |
| tx_tag | output | PTR_W | Slot of the frame |
| len_err | output | 1 | Frame length was clamped |
| cpl_valid | output | 1 | Completion request |
| cpl_index | output | PTR_W | Completed slot |
| cpl_len | output | LEN_W | Completed length |

## Verification
The hardest case to reach is overlap between stages. A descriptor response has to land while the previous payload read is still outstanding, and a doorbell has to arrive in the middle of a batch. The bench sweeps descriptor and payload latency together with the delay before a request is accepted. This moves the relative timing of the two ports through every combination of its small settings. It also rewrites the head while slots are in flight. The ring size and base change between batches, so slot wrap-around happens at several sizes. Descriptor lengths are computed from the slot number, so the clamp boundary at 2048 and values above it recur throughout the run.

// File: rtl/txf_pkg.sv
package txf_pkg;

  localparam int DESC_BYTES = 16;
  localparam int DESC_W     = DESC_BYTES * 8;

  // little-endian descriptor image, most significant field first
  typedef struct packed {
    logic [63:0] buf_addr;
    logic [31:0] buf_len;
    logic [15:0] csum_cmd;
    logic [15:0] unused_pad;
  } desc_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } rd_state_e;

  // byte address of a ring slot: base + (slot masked to ring size) * 16
  function automatic logic [63:0] slot_addr(input logic [63:0] base,
                                            input logic [31:0] slot,
                                            input logic [4:0]  lg);
    logic [31:0] mask;
    mask = (32'd1 << lg) - 32'd1;
    return base + {28'd0, slot & mask, 4'd0};
  endfunction

  function automatic logic [31:0] clamp_len(input logic [31:0] len,
                                            input logic [31:0] cap);
    return (len > cap) ? cap : len;
  endfunction

  function automatic logic over_cap(input logic [31:0] len,
                                    input logic [31:0] cap);
    return len > cap;
  endfunction

endpackage

// File: rtl/txf_ring_fetch.sv
module txf_ring_fetch
  import txf_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int PTR_W  = 16,
  parameter int LOG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [LOG_W-1:0]  ring_log_size,
  input  logic              queue_active,
  input  logic              head_wr_valid,
  input  logic [PTR_W-1:0]  head_wr_ptr,
  input  logic              stage_full,
  output logic              dreq_valid,
  input  logic              dreq_ready,
  output logic [ADDR_W-1:0] dreq_addr,
  output logic [PTR_W-1:0]  dreq_tag,
  input  logic              drsp_valid,
  input  logic [DESC_W-1:0] drsp_data,
  output logic              desc_load,
  output desc_t             desc_word,
  output logic [PTR_W-1:0]  desc_tag,
  output logic              issue_evt
);

  rd_state_e        st_q;
  logic [PTR_W-1:0] head_q;
  logic [PTR_W-1:0] cons_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PTR_W-1:0] tag_q;

  assign issue_evt = (st_q == ST_IDLE) && queue_active &&
                     (cons_q != head_q) && !stage_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      head_q <= '0;
      cons_q <= '0;
      addr_q <= '0;
      tag_q  <= '0;
    end else begin
      if (head_wr_valid) head_q <= head_wr_ptr;
      case (st_q)
        ST_IDLE: if (issue_evt) begin
          addr_q <= ADDR_W'(slot_addr(64'(ring_base), 32'(cons_q), 5'(ring_log_size)));
          tag_q  <= cons_q;
          cons_q <= cons_q + PTR_W'(1);
          st_q   <= ST_REQ;
        end
        ST_REQ:  if (dreq_ready) st_q <= ST_WAIT;
        ST_WAIT: if (drsp_valid) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign dreq_valid = (st_q == ST_REQ);
  assign dreq_addr  = addr_q;
  assign dreq_tag   = tag_q;
  assign desc_load  = (st_q == ST_WAIT) && drsp_valid;
  assign desc_word  = desc_t'(drsp_data);
  assign desc_tag   = tag_q;

endmodule

// File: rtl/txf_payload_stage.sv
module txf_payload_stage
  import txf_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int PTR_W   = 16,
  parameter int MAX_LEN = 2048,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_load,
  input  desc_t             desc_word,
  input  logic [PTR_W-1:0]  desc_tag,
  output logic              stage_full,
  output logic              prq_valid,
  input  logic              prq_ready,
  output logic [ADDR_W-1:0] prq_addr,
  output logic [LEN_W-1:0]  prq_len,
  output logic [PTR_W-1:0]  prq_tag,
  input  logic              prsp_valid,
  output logic              tx_valid,
  output logic [LEN_W-1:0]  tx_len,
  output logic [15:0]       tx_csum_cmd,
  output logic [PTR_W-1:0]  tx_tag,
  output logic              len_err,
  output logic              cpl_valid,
  output logic [PTR_W-1:0]  cpl_index,
  output logic [LEN_W-1:0]  cpl_len,
  output logic [PTR_W-1:0]  tail_ptr,
  output logic              pay_wait,
  output logic [PTR_W-1:0]  pay_tag
);

  localparam logic [31:0] CAP = 32'(MAX_LEN);

  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr;
  logic [LEN_W-1:0]  pend_len;
  logic [15:0]       pend_csum;
  logic              pend_err;
  logic [PTR_W-1:0]  pend_tag;

  rd_state_e         pst_q;
  logic [ADDR_W-1:0] fl_addr;
  logic [LEN_W-1:0]  fl_len;
  logic [15:0]       fl_csum;
  logic              fl_err;
  logic [PTR_W-1:0]  fl_tag;

  logic              txv_q, cplv_q, err_q;
  logic [LEN_W-1:0]  txlen_q;
  logic [15:0]       csum_q;
  logic [PTR_W-1:0]  txtag_q;
  logic [PTR_W-1:0]  tail_q;

  logic unused_pad;
  assign unused_pad = ^desc_word.unused_pad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0; pend_addr <= '0; pend_len <= '0; pend_csum <= '0;
      pend_err <= 1'b0; pend_tag <= '0;
      pst_q <= ST_IDLE; fl_addr <= '0; fl_len <= '0; fl_csum <= '0;
      fl_err <= 1'b0; fl_tag <= '0;
      txv_q <= 1'b0; cplv_q <= 1'b0; err_q <= 1'b0; txlen_q <= '0;
      csum_q <= '0; txtag_q <= '0; tail_q <= '0;
    end else begin
      txv_q  <= 1'b0;
      cplv_q <= 1'b0;
      case (pst_q)
        ST_IDLE: if (pend_q) begin
          fl_addr <= pend_addr; fl_len <= pend_len; fl_csum <= pend_csum;
          fl_err  <= pend_err;  fl_tag <= pend_tag;
          pend_q  <= 1'b0;
          pst_q   <= ST_REQ;
        end
        ST_REQ:  if (prq_ready) pst_q <= ST_WAIT;
        ST_WAIT: if (prsp_valid) begin
          txv_q   <= 1'b1;
          cplv_q  <= 1'b1;
          txlen_q <= fl_len;
          csum_q  <= fl_csum;
          err_q   <= fl_err;
          txtag_q <= fl_tag;
          tail_q  <= tail_q + PTR_W'(1);
          pst_q   <= ST_IDLE;
        end
        default: pst_q <= ST_IDLE;
      endcase
      if (desc_load) begin
        pend_q    <= 1'b1;
        pend_addr <= ADDR_W'(desc_word.buf_addr);
        pend_len  <= LEN_W'(clamp_len(desc_word.buf_len, CAP));
        pend_err  <= over_cap(desc_word.buf_len, CAP);
        pend_csum <= desc_word.csum_cmd;
        pend_tag  <= desc_tag;
      end
    end
  end

  assign stage_full  = pend_q;
  assign prq_valid   = (pst_q == ST_REQ);
  assign prq_addr    = fl_addr;
  assign prq_len     = fl_len;
  assign prq_tag     = fl_tag;
  assign tx_valid    = txv_q;
  assign tx_len      = txlen_q;
  assign tx_csum_cmd = csum_q;
  assign tx_tag      = txtag_q;
  assign len_err     = err_q;
  assign cpl_valid   = cplv_q;
  assign cpl_index   = txtag_q;
  assign cpl_len     = txlen_q;
  assign tail_ptr    = tail_q;
  assign pay_wait    = (pst_q == ST_WAIT);
  assign pay_tag     = fl_tag;

endmodule

// File: rtl/tx_desc_fetch.sv
module tx_desc_fetch
  import txf_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int PTR_W   = 16,
  parameter int LOG_W   = 4,
  parameter int MAX_LEN = 2048,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [LOG_W-1:0]  ring_log_size,
  input  logic              queue_active,
  input  logic              head_wr_valid,
  input  logic [PTR_W-1:0]  head_wr_ptr,
  output logic [PTR_W-1:0]  tail_ptr,
  output logic              dreq_valid,
  input  logic              dreq_ready,
  output logic [ADDR_W-1:0] dreq_addr,
  output logic [LEN_W-1:0]  dreq_len,
  output logic [PTR_W-1:0]  dreq_tag,
  input  logic              drsp_valid,
  input  logic [127:0]      drsp_data,
  output logic              prq_valid,
  input  logic              prq_ready,
  output logic [ADDR_W-1:0] prq_addr,
  output logic [LEN_W-1:0]  prq_len,
  output logic [PTR_W-1:0]  prq_tag,
  input  logic              prsp_valid,
  output logic              tx_valid,
  output logic [LEN_W-1:0]  tx_len,
  output logic [15:0]       tx_csum_cmd,
  output logic [PTR_W-1:0]  tx_tag,
  output logic              len_err,
  output logic              cpl_valid,
  output logic [PTR_W-1:0]  cpl_index,
  output logic [LEN_W-1:0]  cpl_len
);

  // internal events, named for the checker
  logic             stage_full;
  logic             desc_load;
  desc_t            desc_word;
  logic [PTR_W-1:0] desc_tag;
  logic             issue_evt;
  logic             pay_wait;
  logic [PTR_W-1:0] pay_tag;

  assign dreq_len = LEN_W'(DESC_BYTES);

  txf_ring_fetch #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .LOG_W(LOG_W)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .ring_base(ring_base), .ring_log_size(ring_log_size),
    .queue_active(queue_active),
    .head_wr_valid(head_wr_valid), .head_wr_ptr(head_wr_ptr),
    .stage_full(stage_full),
    .dreq_valid(dreq_valid), .dreq_ready(dreq_ready),
    .dreq_addr(dreq_addr), .dreq_tag(dreq_tag),
    .drsp_valid(drsp_valid), .drsp_data(drsp_data),
    .desc_load(desc_load), .desc_word(desc_word), .desc_tag(desc_tag),
    .issue_evt(issue_evt)
  );

  txf_payload_stage #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .MAX_LEN(MAX_LEN)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .desc_load(desc_load), .desc_word(desc_word), .desc_tag(desc_tag),
    .stage_full(stage_full),
    .prq_valid(prq_valid), .prq_ready(prq_ready),
    .prq_addr(prq_addr), .prq_len(prq_len), .prq_tag(prq_tag),
    .prsp_valid(prsp_valid),
    .tx_valid(tx_valid), .tx_len(tx_len), .tx_csum_cmd(tx_csum_cmd),
    .tx_tag(tx_tag), .len_err(len_err),
    .cpl_valid(cpl_valid), .cpl_index(cpl_index), .cpl_len(cpl_len),
    .tail_ptr(tail_ptr), .pay_wait(pay_wait), .pay_tag(pay_tag)
  );

endmodule

// File: rtl/tx_desc_fetch_checker.sv
module tx_desc_fetch_checker #(
  parameter int ADDR_W  = 64,
  parameter int PTR_W   = 16,
  parameter int MAX_LEN = 2048,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              queue_active,
  input logic              dreq_valid,
  input logic              dreq_ready,
  input logic [ADDR_W-1:0] dreq_addr,
  input logic              drsp_valid,
  input logic              prq_valid,
  input logic              prq_ready,
  input logic [ADDR_W-1:0] prq_addr,
  input logic              prsp_valid,
  input logic              tx_valid,
  input logic [LEN_W-1:0]  tx_len,
  input logic              cpl_valid,
  input logic [PTR_W-1:0]  cpl_index,
  input logic [PTR_W-1:0]  tail_ptr,
  input logic              pay_wait,
  input logic [PTR_W-1:0]  pay_tag
);

  p_dreq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_valid && !dreq_ready |=> dreq_valid && $stable(dreq_addr));

  p_prq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    prq_valid && !prq_ready |=> prq_valid && $stable(prq_addr));

  p_one_desc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    drsp_valid |-> !dreq_valid);

  p_inactive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dreq_valid) |-> $past(queue_active));

  p_tail_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tail_ptr == $past(tail_ptr) + PTR_W'(1));

  p_tail_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |-> $stable(tail_ptr));

  p_tag_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prsp_valid && pay_wait |-> pay_tag == tail_ptr);

  p_len_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_len <= LEN_W'(MAX_LEN));

  p_cpl_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> cpl_valid && cpl_index == $past(tail_ptr));

endmodule

bind tx_desc_fetch tx_desc_fetch_checker #(
  .ADDR_W(ADDR_W), .PTR_W(PTR_W), .MAX_LEN(MAX_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .queue_active(queue_active),
  .dreq_valid(dreq_valid), .dreq_ready(dreq_ready), .dreq_addr(dreq_addr),
  .drsp_valid(drsp_valid),
  .prq_valid(prq_valid), .prq_ready(prq_ready), .prq_addr(prq_addr),
  .prsp_valid(prsp_valid),
  .tx_valid(tx_valid), .tx_len(tx_len),
  .cpl_valid(cpl_valid), .cpl_index(cpl_index),
  .tail_ptr(tail_ptr), .pay_wait(pay_wait), .pay_tag(pay_tag)
);

// File: tb/tx_desc_fetch_bench.sv
`timescale 1ns/1ps
module tx_desc_fetch_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [63:0]  ring_base = 64'h0;
  logic [3:0]   ring_log_size = 4'd3;
  logic         queue_active = 1'b0;
  logic         head_wr_valid = 1'b0;
  logic [15:0]  head_wr_ptr = 16'd0;
  logic [15:0]  tail_ptr;
  logic         dreq_valid;
  logic         dreq_ready = 1'b0;
  logic [63:0]  dreq_addr;
  logic [11:0]  dreq_len;
  logic [15:0]  dreq_tag;
  logic         drsp_valid = 1'b0;
  logic [127:0] drsp_data = '0;
  logic         prq_valid;
  logic         prq_ready = 1'b0;
  logic [63:0]  prq_addr;
  logic [11:0]  prq_len;
  logic [15:0]  prq_tag;
  logic         prsp_valid = 1'b0;
  logic         tx_valid;
  logic [11:0]  tx_len;
  logic [15:0]  tx_csum_cmd;
  logic [15:0]  tx_tag;
  logic         len_err;
  logic         cpl_valid;
  logic [15:0]  cpl_index;
  logic [11:0]  cpl_len;

  always #10 clk = ~clk;

  tx_desc_fetch u_tx_desc_fetch (.*);

  int checks = 0, failures = 0;
  int dcount = 0, pcount = 0, frames = 0;
  int lat_v = 0, rdly_v = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int blen(input int t);
    if (t % 7 == 3) return 2049 + (t % 4) * 300;
    if (t % 7 == 5) return 2048;
    return 1 + ((t * 97) % 1500);
  endfunction
  function automatic longint baddr(input int t);
    return 64'h0000_0100_0000_0000 + longint'(t) * 64'h1000;
  endfunction
  function automatic int clen(input int t);
    return (blen(t) > 2048) ? 2048 : blen(t);
  endfunction
  function automatic logic [15:0] csum_of(input int t);
    return 16'(t) ^ 16'hA5A5;
  endfunction

  // descriptor memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (dreq_valid) begin
        chk(dreq_tag == 16'(dcount), "R2", "desc tag", dreq_tag, dcount);
        chk(dreq_len == 12'd16, "R3", "desc len", dreq_len, 16);
        chk(dreq_addr == ring_base + 64'((dcount % (1 << ring_log_size)) * 16),
            "R3", "desc addr", dreq_addr,
            ring_base + 64'((dcount % (1 << ring_log_size)) * 16));
        for (int k = 0; k < rdly_v; k++) begin
          @(negedge clk);
          chk(dreq_valid == 1'b1, "R10", "desc req held", dreq_valid, 1);
        end
        dreq_ready = 1'b1;
        @(negedge clk);
        dreq_ready = 1'b0;
        for (int k = 0; k < lat_v; k++) @(negedge clk);
        drsp_data = {64'(baddr(dcount)), 32'(blen(dcount)), csum_of(dcount), 16'hFFFF};
        drsp_valid = 1'b1;
        dcount++;
        @(negedge clk);
        drsp_valid = 1'b0;
      end
    end
  end

  // payload memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (prq_valid) begin
        chk(prq_tag == 16'(pcount), "R4", "pay tag", prq_tag, pcount);
        chk(prq_addr == 64'(baddr(pcount)), "R4", "pay addr", prq_addr, baddr(pcount));
        chk(prq_len == 12'(clen(pcount)), "R5", "pay len", prq_len, clen(pcount));
        for (int k = 0; k < rdly_v; k++) begin
          @(negedge clk);
          chk(prq_valid == 1'b1, "R10", "pay req held", prq_valid, 1);
        end
        prq_ready = 1'b1;
        @(negedge clk);
        prq_ready = 1'b0;
        for (int k = 0; k < lat_v; k++) @(negedge clk);
        prsp_valid = 1'b1;
        pcount++;
        @(negedge clk);
        prsp_valid = 1'b0;
      end
    end
  end

  // frame and completion monitor
  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      chk(tx_tag == 16'(frames), "R6", "frame tag", tx_tag, frames);
      chk(tx_len == 12'(clen(frames)), "R5", "frame len", tx_len, clen(frames));
      chk(len_err == (blen(frames) > 2048), "R5", "len_err", len_err, blen(frames) > 2048);
      chk(tx_csum_cmd == csum_of(frames), "R4", "csum", tx_csum_cmd, csum_of(frames));
      chk(tail_ptr == 16'(frames + 1), "R7", "tail", tail_ptr, frames + 1);
      chk(cpl_valid && cpl_index == 16'(frames) && cpl_len == 12'(clen(frames)),
          "R8", "completion", {cpl_valid, cpl_index, cpl_len}, {1'b1, 16'(frames), 12'(clen(frames))});
      frames++;
    end else if (rst_n && cpl_valid) begin
      chk(0, "R8", "lone completion", cpl_valid, 0);
    end
  end

  task automatic ring(input int h);
    @(negedge clk);
    head_wr_valid = 1'b1;
    head_wr_ptr   = 16'(h);
    @(negedge clk);
    head_wr_valid = 1'b0;
  endtask

  task automatic wait_done(input int target, input string req);
    int n = 0;
    while ((frames != target || dcount != target) && n < 4000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    chk(frames == target, req, "frames served", frames, target);
    chk(dcount == target, "R2", "descriptor reads", dcount, target);
    chk(tail_ptr == 16'(target), "R7", "tail at end", tail_ptr, target);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int head = 0;
    ring_base = 64'h8000_0000;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(tail_ptr == 0 && !dreq_valid && !prq_valid && !tx_valid && !cpl_valid,
        "R1", "in reset", {tail_ptr, dreq_valid, prq_valid, tx_valid, cpl_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tail_ptr == 0 && !dreq_valid && !prq_valid && !tx_valid && !cpl_valid,
        "R1", "after reset", {tail_ptr, dreq_valid, prq_valid, tx_valid, cpl_valid}, 0);

    // R9 inactive queue holds off reads
    ring(3);
    repeat (20) @(negedge clk);
    chk(dcount == 0 && !dreq_valid, "R9", "reads while inactive", dcount, 0);
    queue_active = 1'b1;
    wait_done(3, "R9");
    head = 3;

    // R3 wrap within an 8-slot ring
    ring(13);
    wait_done(13, "R3");

    // R11 doorbell during a batch
    ring(15);
    repeat (2) @(negedge clk);
    ring(20);
    wait_done(20, "R11");
    head = 20;

    // sweep latency, accept delay and ring size
    for (int lat = 0; lat < 3; lat++)
      for (int rd = 0; rd < 3; rd++)
        for (int lg = 1; lg < 4; lg++) begin
          lat_v = lat;
          rdly_v = rd;
          ring_log_size = 4'(lg);
          ring_base = 64'h8000_0000 + 64'((lat * 9 + rd * 3 + lg) * 32'h1_0000);
          head += 1 + ((lat + rd + lg) % 4);
          ring(head);
          wait_done(head, "R6");
        end

    // R2 repeated head issues nothing
    ring(head);
    repeat (20) @(negedge clk);
    chk(dcount == head && !dreq_valid, "R2", "repeat doorbell", dcount, head);

    summary();
  end

endmodule